// File: doc/BRIEF.md
# Amplifier Self-Healing Search Controller

This block tunes the actuators of an on-chip power amplifier after power-up without any outside help. On a run command it first switches the amplifier off and reads every sensor to learn each channel's zero-signal baseline. It then steps through every actuation state in turn. For each state it loads two bias control codes and the tunable stub settings, waits a settling time, reads all twelve sensor channels through three shared serial ADCs, and scores the state. At the end it loads the best state and raises a done flag.

Two scoring modes exist. The first keeps the state with the highest output-power figure. The second keeps the state with the lowest dc-power figure among the states whose output power reaches a target code. If no state reaches the target, the second mode falls back to the highest-power state and flags the failure. Each sensor offset is removed from later readings before scoring. The output-power figure is the forward reading minus the reflected reading at the output coupler. The dc-power figure is the sum of the two output-stage current readings.

The actuation state packs the common-source code in the low bits, the cascode-gate code above it, and then one 3-bit index per stub. With the default parameters this gives 6 + 6 + 2×3 = 18 bits, or 262,144 states.

Top module: `shc_top`

## Requirements
- R1: After reset: done and fail are low, no ADC start line is high, the amplifier-off bit (the MSB of cs_dac) is 1, all bias codes are 0 and all stub switches are open.
- R2: Once run is seen high, the first read pass takes place with the amplifier-off bit at 1. The value each channel returns in that pass becomes its offset. Every later reading is reduced by its channel's offset, and a result below zero is taken as zero.
- R3: During a search read, the amplifier-off bit is 0. cs_dac[DAC_W-1:0] carries state bits [DAC_W-1:0]. cg_dac carries state bits [2·DAC_W-1:DAC_W]. Stub k takes its index from state bits starting at 2·DAC_W + k·3.
- R4: A stub index i closes switches 0 to i-1 of that stub's group and opens the rest. Index 0 opens all seven switches, which selects the longest stub.
- R5: A read pass has four rounds, numbered m = 0 to 3. In round m the mux select holds m, and all three start lines go high together for exactly one cycle. Each ADC returns its 8-bit value MSB first, one bit per cycle. Bit 7 is taken at the second rising edge after the edge that raised start, and the lower bits are taken at the following edges. Channel number = 4 × ADC index + mux select.
- R6: After the offset pass, the search reads every actuation state exactly once, in ascending order from 0 to all ones, with one read pass per state.
- R7: Output-power figure = corrected channel 2 − corrected channel 3, with a negative result taken as zero. In mode 0 the result is the state with the highest figure. On a tie the earlier state is kept.
- R8: dc figure = corrected channel 6 + corrected channel 7. In mode 1 the result is the state with the lowest dc figure among states whose output-power figure is greater than or equal to target. On a tie the earlier state is kept.
- R9: If no state qualifies in mode 1, the result is the mode-0 state and fail goes to 1. In every other case fail is 0.
- R10: When done goes high, the actuators hold the result state with the amplifier on. done stays high until run goes low. The actuators do not change after done.
- R11: mode and target are sampled on the cycle the run starts. Changes to them during the run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Level; starts a healing run from idle and must stay high until done |
| mode | input | 1 | 0 = maximum output power, 1 = minimum dc power above target |
| target | input | ADC_W | Output-power floor for mode 1, in corrected sensor codes |
| cs_dac | output | DAC_W+1 | Common-source bias word; MSB forces the DAC output to zero |
| cg_dac | output | DAC_W | Cascode-gate bias code |
| stub_sw | output | N_STUB·7 | Stub shorting switches, seven per stub, thermometer coded |
| adc_start | output | 3 | One-cycle conversion start, one line per ADC |
| adc_mux | output | 2 | Sensor select shared by the three ADCs |
| adc_sdata | input | 3 | Serial result bit from each ADC |
| done | output | 1 | Healing finished; result state loaded |
| fail | output | 1 | Mode 1 found no state meeting the target |

## Verification
A start pulse appears one cycle after the round begins. The serial model loads its word at the next edge and shifts it out MSB first over the eight edges that follow. The bench checks the mux select and the actuator word at the falling edge of every start pulse. For a search state, the actuators are loaded at least SETTLE+1 cycles before the first start of that state's pass. The done flag follows the last conversion after a fixed chain: store, handshake, four evaluation steps, update and final load. The bench therefore polls done at falling edges and checks the result actuators and fail in the first cycle done is high. It checks that done falls one cycle after run is released.

// File: rtl/shc_pkg.sv
package shc_pkg;

   localparam int N_ADC  = 3;
   localparam int N_MUX  = 4;
   localparam int N_CH   = N_ADC * N_MUX;
   localparam int CH_W   = $clog2(N_CH);
   localparam int MUX_W  = $clog2(N_MUX);
   localparam int N_FIG  = 4;

   // channel number = adc * N_MUX + mux
   localparam int CH_OUT_FWD = 0 * N_MUX + 2;
   localparam int CH_OUT_REV = 0 * N_MUX + 3;
   localparam int CH_DC_A    = 1 * N_MUX + 2;
   localparam int CH_DC_B    = 1 * N_MUX + 3;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CAL_LD,
      S_CAL_SET,
      S_CAL_RD,
      S_CAL_SAV,
      S_LD,
      S_SET,
      S_RD,
      S_EVAL,
      S_UPD,
      S_FIN,
      S_DONE
   } heal_st_t;

   // evaluation step k -> channel whose corrected value lands in figure slot k
   function automatic logic [CH_W-1:0] fig_chan(input logic [1:0] k);
      case (k)
         2'd0:    fig_chan = CH_W'(CH_OUT_FWD);
         2'd1:    fig_chan = CH_W'(CH_OUT_REV);
         2'd2:    fig_chan = CH_W'(CH_DC_A);
         default: fig_chan = CH_W'(CH_DC_B);
      endcase
   endfunction

endpackage

// File: rtl/shc_act_drive.sv
module shc_act_drive #(
   parameter int DAC_W   = 6,
   parameter int N_STUB  = 2,
   parameter int STUB_IW = 3,
   localparam int SW     = (1 << STUB_IW) - 1,
   localparam int ST_W   = 2 * DAC_W + N_STUB * STUB_IW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic                   amp_off,
   input  logic [ST_W-1:0]        state,
   output logic [DAC_W:0]         cs_dac,
   output logic [DAC_W-1:0]       cg_dac,
   output logic [N_STUB*SW-1:0]   stub_sw
);

   function automatic logic [SW-1:0] therm(input logic [STUB_IW-1:0] idx);
      logic [SW-1:0] v;
      for (int j = 0; j < SW; j++) begin
         v[j] = (j < int'(idx));
      end
      return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_dac <= {1'b1, {DAC_W{1'b0}}};
         cg_dac <= '0;
      end else if (load) begin
         cs_dac <= {amp_off, state[DAC_W-1:0]};
         cg_dac <= state[2*DAC_W-1:DAC_W];
      end
   end

   for (genvar k = 0; k < N_STUB; k++) begin : g_stub
      logic [SW-1:0] sw_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sw_q <= '0;
         end else if (load) begin
            sw_q <= therm(state[2*DAC_W + k*STUB_IW +: STUB_IW]);
         end
      end
      assign stub_sw[k*SW +: SW] = sw_q;
   end

endmodule

// File: rtl/shc_sense_read.sv
module shc_sense_read
   import shc_pkg::*;
#(
   parameter int ADC_W   = 8,
   localparam int N_SMP  = N_ADC * N_MUX,
   localparam int BIT_W  = $clog2(ADC_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [N_ADC-1:0]     adc_sdata,
   output logic [N_ADC-1:0]     adc_start,
   output logic [MUX_W-1:0]     adc_mux,
   output logic                 done,
   input  logic [CH_W-1:0]      rd_sel,
   output logic [ADC_W-1:0]     rd_data
);

   typedef enum logic [2:0] {R_IDLE, R_START, R_GAP, R_RECV, R_STORE} rd_ph_t;

   rd_ph_t                        ph;
   logic [MUX_W-1:0]              round_q;
   logic [BIT_W-1:0]              bit_q;
   logic                          start_q;
   logic                          done_q;
   logic [N_ADC-1:0][ADC_W-1:0]   sh;
   logic [ADC_W-1:0]              smp [N_SMP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= R_IDLE;
         round_q <= '0;
         bit_q   <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (ph)
            R_IDLE: begin
               if (go) begin
                  round_q <= '0;
                  ph      <= R_START;
               end
            end
            R_START: begin
               start_q <= 1'b1;
               ph      <= R_GAP;
            end
            R_GAP: begin
               start_q <= 1'b0;
               bit_q   <= '0;
               ph      <= R_RECV;
            end
            R_RECV: begin
               bit_q <= bit_q + 1'b1;
               if (bit_q == BIT_W'(ADC_W - 1)) ph <= R_STORE;
            end
            default: begin
               if (round_q == MUX_W'(N_MUX - 1)) begin
                  done_q <= 1'b1;
                  ph     <= R_IDLE;
               end else begin
                  round_q <= round_q + 1'b1;
                  ph      <= R_START;
               end
            end
         endcase
      end
   end

   // one serial receiver per converter
   for (genvar a = 0; a < N_ADC; a++) begin : g_adc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh[a] <= '0;
         end else if (ph == R_RECV) begin
            sh[a] <= {sh[a][ADC_W-2:0], adc_sdata[a]};
         end
      end
      assign adc_start[a] = start_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SMP; i++) smp[i] <= '0;
      end else if (ph == R_STORE) begin
         for (int a = 0; a < N_ADC; a++) begin
            smp[a*N_MUX + int'(round_q)] <= sh[a];
         end
      end
   end

   assign adc_mux = round_q;
   assign done    = done_q;
   assign rd_data = (int'(rd_sel) < N_SMP) ? smp[rd_sel] : '0;

endmodule

// File: rtl/shc_best_track.sv
module shc_best_track #(
   parameter int ST_W = 18,
   parameter int PW   = 8,
   localparam int DW  = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [ST_W-1:0]   state,
   input  logic [PW-1:0]     pout,
   input  logic [DW-1:0]     pdc,
   input  logic [PW-1:0]     target,
   output logic [ST_W-1:0]   max_state,
   output logic [ST_W-1:0]   min_state,
   output logic              min_found
);

   logic          have_max;
   logic [PW-1:0] max_p;
   logic [DW-1:0] min_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_max  <= 1'b0;
         max_p     <= '0;
         max_state <= '0;
         min_found <= 1'b0;
         min_d     <= '0;
         min_state <= '0;
      end else if (clr) begin
         have_max  <= 1'b0;
         min_found <= 1'b0;
      end else if (upd) begin
         // strict compares keep the earliest state on a tie
         if (!have_max || (pout > max_p)) begin
            have_max  <= 1'b1;
            max_p     <= pout;
            max_state <= state;
         end
         if ((pout >= target) && (!min_found || (pdc < min_d))) begin
            min_found <= 1'b1;
            min_d     <= pdc;
            min_state <= state;
         end
      end
   end

endmodule

// File: rtl/shc_top.sv
module shc_top
   import shc_pkg::*;
#(
   parameter int DAC_W   = 6,
   parameter int N_STUB  = 2,
   parameter int STUB_IW = 3,
   parameter int ADC_W   = 8,
   parameter int SETTLE  = 4,
   localparam int SW     = (1 << STUB_IW) - 1,
   localparam int ST_W   = 2 * DAC_W + N_STUB * STUB_IW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   mode,
   input  logic [ADC_W-1:0]       target,
   output logic [DAC_W:0]         cs_dac,
   output logic [DAC_W-1:0]       cg_dac,
   output logic [N_STUB*SW-1:0]   stub_sw,
   output logic [N_ADC-1:0]       adc_start,
   output logic [MUX_W-1:0]       adc_mux,
   input  logic [N_ADC-1:0]       adc_sdata,
   output logic                   done,
   output logic                   fail
);

   localparam int CNT_MAX = (SETTLE > N_CH) ? SETTLE : N_CH;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (DAC_W < 1) begin : g_bad_dac
      $error("shc_top: DAC_W must be at least 1");
   end
   if (N_STUB < 1) begin : g_bad_stub
      $error("shc_top: N_STUB must be at least 1");
   end
   if (STUB_IW < 1) begin : g_bad_iw
      $error("shc_top: STUB_IW must be at least 1");
   end
   if (ADC_W < 2) begin : g_bad_adc
      $error("shc_top: ADC_W must be at least 2");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("shc_top: SETTLE must be at least 1");
   end

   heal_st_t          st;
   logic [ST_W-1:0]   idx;
   logic              mode_q;
   logic [ADC_W-1:0]  tgt_q;
   logic              fail_q;
   logic [CNT_W-1:0]  cnt;
   logic [ADC_W-1:0]  off_q [N_CH];
   logic [ADC_W-1:0]  fig_q [N_FIG];

   logic              act_ld;
   logic              act_off;
   logic [ST_W-1:0]   act_state;
   logic [ST_W-1:0]   fin_state;
   logic              rd_go;
   logic              rd_done;
   logic [CH_W-1:0]   rd_sel;
   logic [ADC_W-1:0]  rd_data;
   logic [ADC_W-1:0]  corr;
   logic [ADC_W-1:0]  pout;
   logic [ADC_W:0]    pdc;
   logic [ST_W-1:0]   max_s;
   logic [ST_W-1:0]   min_s;
   logic              found;
   logic              settled;

   // ---------------- sequencing ----------------
   assign settled = (cnt == CNT_W'(SETTLE - 1));
   assign rd_go   = ((st == S_CAL_SET) || (st == S_SET)) && settled;
   assign act_ld  = (st == S_CAL_LD) || (st == S_LD) || (st == S_FIN);
   assign act_off = (st == S_CAL_LD);
   assign fin_state = (mode_q && found) ? min_s : max_s;

   always_comb begin
      case (st)
         S_CAL_LD: act_state = '0;
         S_FIN:    act_state = fin_state;
         default:  act_state = idx;
      endcase
   end

   assign rd_sel = (st == S_CAL_SAV) ? cnt[CH_W-1:0] : fig_chan(cnt[1:0]);
   assign corr   = (rd_data > off_q[rd_sel]) ? (rd_data - off_q[rd_sel]) : '0;
   assign pout   = (fig_q[0] > fig_q[1]) ? (fig_q[0] - fig_q[1]) : '0;
   assign pdc    = {1'b0, fig_q[2]} + {1'b0, fig_q[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         idx    <= '0;
         mode_q <= 1'b0;
         tgt_q  <= '0;
         fail_q <= 1'b0;
         cnt    <= '0;
         for (int i = 0; i < N_CH; i++)  off_q[i] <= '0;
         for (int i = 0; i < N_FIG; i++) fig_q[i] <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (run) begin
                  mode_q <= mode;
                  tgt_q  <= target;
                  idx    <= '0;
                  fail_q <= 1'b0;
                  st     <= S_CAL_LD;
               end
            end
            S_CAL_LD, S_LD: begin
               cnt <= '0;
               st  <= (st == S_CAL_LD) ? S_CAL_SET : S_SET;
            end
            S_CAL_SET, S_SET: begin
               if (settled) st <= (st == S_CAL_SET) ? S_CAL_RD : S_RD;
               else         cnt <= cnt + 1'b1;
            end
            S_CAL_RD, S_RD: begin
               if (rd_done) begin
                  cnt <= '0;
                  st  <= (st == S_CAL_RD) ? S_CAL_SAV : S_EVAL;
               end
            end
            S_CAL_SAV: begin
               off_q[cnt[CH_W-1:0]] <= rd_data;
               if (cnt == CNT_W'(N_CH - 1)) st  <= S_LD;
               else                         cnt <= cnt + 1'b1;
            end
            S_EVAL: begin
               fig_q[cnt[1:0]] <= corr;
               if (cnt == CNT_W'(N_FIG - 1)) st  <= S_UPD;
               else                          cnt <= cnt + 1'b1;
            end
            S_UPD: begin
               if (&idx) begin
                  st <= S_FIN;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= S_LD;
               end
            end
            S_FIN: begin
               fail_q <= mode_q && !found;
               st     <= S_DONE;
            end
            default: begin
               if (!run) st <= S_IDLE;
            end
         endcase
      end
   end

   assign done = (st == S_DONE);
   assign fail = fail_q;

   // ---------------- sub-units ----------------
   shc_act_drive #(
      .DAC_W   (DAC_W),
      .N_STUB  (N_STUB),
      .STUB_IW (STUB_IW)
   ) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (act_ld),
      .amp_off (act_off),
      .state   (act_state),
      .cs_dac  (cs_dac),
      .cg_dac  (cg_dac),
      .stub_sw (stub_sw)
   );

   shc_sense_read #(
      .ADC_W (ADC_W)
   ) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (rd_go),
      .adc_sdata (adc_sdata),
      .adc_start (adc_start),
      .adc_mux   (adc_mux),
      .done      (rd_done),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data)
   );

   shc_best_track #(
      .ST_W (ST_W),
      .PW   (ADC_W)
   ) u_best (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       ((st == S_IDLE) && run),
      .upd       (st == S_UPD),
      .state     (idx),
      .pout      (pout),
      .pdc       (pdc),
      .target    (tgt_q),
      .max_state (max_s),
      .min_state (min_s),
      .min_found (found)
   );

endmodule

// File: rtl/shc_chk.sv
module shc_chk
   import shc_pkg::*;
#(
   parameter int DAC_W  = 6,
   parameter int SW_TOT = 14
) (
   input logic               clk,
   input logic               rst_n,
   input heal_st_t           st,
   input logic [N_ADC-1:0]   adc_start,
   input logic [MUX_W-1:0]   adc_mux,
   input logic [DAC_W:0]     cs_dac,
   input logic [DAC_W-1:0]   cg_dac,
   input logic [SW_TOT-1:0]  stub_sw,
   input logic               done,
   input logic               fail
);

   a_r2_cal_amp_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_CAL_RD) && adc_start[0]) |-> cs_dac[DAC_W]);

   a_r3_search_amp_on: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_RD) && adc_start[0]) |-> !cs_dac[DAC_W]);

   a_r5_start_together: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start != '0) |-> (&adc_start));

   a_r5_mux_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_start[0]) |-> $stable(adc_mux));

   a_r9_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);

   a_r10_result_amp_on: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cs_dac[DAC_W]);

   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(cs_dac) && $stable(cg_dac) && $stable(stub_sw)));

endmodule

bind shc_top shc_chk #(
   .DAC_W  (DAC_W),
   .SW_TOT (N_STUB * SW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st),
   .adc_start (adc_start),
   .adc_mux   (adc_mux),
   .cs_dac    (cs_dac),
   .cg_dac    (cg_dac),
   .stub_sw   (stub_sw),
   .done      (done),
   .fail      (fail)
);

// File: tb/tb_shc_top.sv
`timescale 1ns/1ps
module tb_shc_top;

   localparam int DAC_W = 2;
   localparam int NS    = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       mode = 1'b0;
   logic [7:0] target = '0;
   logic [2:0] cs_dac;
   logic [1:0] cg_dac;
   logic [6:0] stub_sw;
   logic [2:0] adc_start;
   logic [1:0] adc_mux;
   logic [2:0] adc_sdata;
   logic       done;
   logic       fail;

   int checks = 0;
   int failures = 0;
   int k[6];
   int offs[12];
   int mon_round = 0;
   int mon_pass = 0;
   logic [2:0][7:0] sh_m;

   always #2.5 clk = ~clk;

   shc_top #(
      .DAC_W(DAC_W), .N_STUB(1), .STUB_IW(3), .ADC_W(8), .SETTLE(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .target(target),
      .cs_dac(cs_dac), .cg_dac(cg_dac), .stub_sw(stub_sw),
      .adc_start(adc_start), .adc_mux(adc_mux), .adc_sdata(adc_sdata),
      .done(done), .fail(fail)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] therm(input int i);
      logic [6:0] v;
      for (int j = 0; j < 7; j++) v[j] = (j < i);
      return v;
   endfunction

   // behavioural sensor values above the offset, per channel and state
   function automatic int sval(input int ch, input int s);
      case (ch)
         2:       return 40 + (s * k[0] + k[1]) % 120;
         3:       return (s * k[2] + k[3]) % 60;
         6:       return (s * k[4] + k[5]) % 90;
         7:       return (s * k[4] * 3 + k[5] + 7) % 90;
         default: return (s * 7 + ch * 11) % 100;
      endcase
   endfunction

   function automatic int pout_of(input int s);
      int f = sval(2, s);
      int r = sval(3, s);
      return (f > r) ? f - r : 0;
   endfunction

   function automatic int pdc_of(input int s);
      return sval(6, s) + sval(7, s);
   endfunction

   function automatic int raw(input int ch);
      int s;
      if (cs_dac[2]) return offs[ch];
      s = ($countones(stub_sw) << 4) | (int'(cg_dac) << 2) | int'(cs_dac[1:0]);
      return offs[ch] + sval(ch, s);
   endfunction

   // serial ADC models: load on start, then shift MSB first
   always @(posedge clk) begin
      for (int a = 0; a < 3; a++) begin
         if (adc_start[a]) sh_m[a] <= 8'(raw(a * 4 + int'(adc_mux)));
         else              sh_m[a] <= {sh_m[a][6:0], 1'b0};
      end
   end
   assign adc_sdata = {sh_m[2][7], sh_m[1][7], sh_m[0][7]};

   // conversion monitor: R5 protocol, R2 offset pass, R3/R4/R6 state order
   always @(negedge clk) begin
      if (rst_n && (adc_start != 3'b000)) begin
         chk(adc_start == 3'b111, "R5 starts together", adc_start, 7);
         chk(int'(adc_mux) == mon_round, "R5 mux round", adc_mux, mon_round);
         if (mon_pass == 0) begin
            chk(cs_dac[2] == 1'b1, "R2 offset pass amp off", cs_dac[2], 1);
         end else begin
            chk(cs_dac == {1'b0, 2'((mon_pass - 1) & 3)}, "R3 R6 cs word",
                cs_dac, (mon_pass - 1) & 3);
            chk(cg_dac == 2'(((mon_pass - 1) >> 2) & 3), "R3 R6 cg code",
                cg_dac, ((mon_pass - 1) >> 2) & 3);
            chk(stub_sw == therm((mon_pass - 1) >> 4), "R4 R6 stub pattern",
                stub_sw, therm((mon_pass - 1) >> 4));
         end
         if (mon_round == 3) begin
            mon_round = 0;
            mon_pass  = mon_pass + 1;
         end else begin
            mon_round = mon_round + 1;
         end
      end
   end

   task automatic setup(input bit tie);
      for (int i = 0; i < 6; i++) k[i] = 1 + int'($urandom % 97);
      if (tie) begin
         k[0] = 0;
         k[2] = 0;
         k[4] = 0;
      end
      for (int i = 0; i < 12; i++) offs[i] = int'($urandom % 41);
   endtask

   task automatic do_run(input bit md, input int tg, input bit swap, input string tag);
      int cyc;
      int bm, bmp, bn, bnd, es;
      bit ef;
      logic [2:0] cs_h;
      logic [1:0] cg_h;
      logic [6:0] sw_h;
      @(negedge clk);
      mon_round = 0;
      mon_pass  = 0;
      mode   = md;
      target = 8'(tg);
      run    = 1'b1;
      if (swap) begin
         repeat (30) @(negedge clk);
         mode   = ~md;
         target = 8'd0;
      end
      cyc = 0;
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R10 watchdog: done not seen actual=%0d expected=1", done);
      end
      // expected result from requirements (R7, R8, R9, R11)
      bm = 0; bmp = -1; bn = -1; bnd = 1 << 20;
      for (int s = 0; s < NS; s++) begin
         if (pout_of(s) > bmp) begin bmp = pout_of(s); bm = s; end
         if (pout_of(s) >= tg && pdc_of(s) < bnd) begin bnd = pdc_of(s); bn = s; end
      end
      if (md && bn >= 0) begin es = bn; ef = 1'b0; end
      else               begin es = bm; ef = md; end
      chk(cs_dac == {1'b0, 2'(es & 3)}, {tag, " result cs"}, cs_dac, es & 3);
      chk(cg_dac == 2'((es >> 2) & 3), {tag, " result cg"}, cg_dac, (es >> 2) & 3);
      chk(stub_sw == therm(es >> 4), {tag, " result stub"}, stub_sw, therm(es >> 4));
      chk(fail == ef, {tag, " R9 fail flag"}, fail, ef);
      chk(mon_pass == NS + 1 && mon_round == 0, "R6 pass count", mon_pass, NS + 1);
      cs_h = cs_dac; cg_h = cg_dac; sw_h = stub_sw;
      run  = 1'b0;
      mode = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R10 done falls with run", done, 0);
      chk(cs_dac == cs_h && cg_dac == cg_h && stub_sw == sw_h,
          "R10 actuators held", {cs_dac, cg_dac, stub_sw}, {cs_h, cg_h, sw_h});
   endtask

   initial begin
      int seed_v;
      seed_v = int'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 0 && fail == 0, "R1 flags low", {done, fail}, 0);
      chk(adc_start == 3'b000, "R1 no start", adc_start, 0);
      chk(cs_dac == 3'b100, "R1 amp off", cs_dac, 4);
      chk(cg_dac == 2'b00 && stub_sw == 7'd0, "R1 codes zero", {cg_dac, stub_sw}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done == 0 && adc_start == 3'b000, "R1 idle without run", {done, adc_start}, 0);

      setup(1'b0);
      do_run(1'b0, 0, 1'b0, "R7 R2 max power");
      setup(1'b0);
      do_run(1'b1, pout_of(NS / 2), 1'b0, "R8 min dc");
      setup(1'b0);
      do_run(1'b1, 255, 1'b0, "R9 no state meets target");
      setup(1'b1);
      do_run(1'b0, 0, 1'b0, "R7 tie keeps earliest");
      setup(1'b1);
      do_run(1'b1, 0, 1'b0, "R8 tie keeps earliest");
      setup(1'b0);
      do_run(1'b1, pout_of(NS / 3), 1'b1, "R11 inputs sampled at start");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule